// File: doc/BRIEF.md
# Secure-Attribute Configuration Register Guard

This block is a small register slice on a 32-bit peripheral bus that enforces a layered write policy. It holds two registers: a security policy register whose four low bits each mark one protected register group as writable by secure masters only, and a floating-point exception interrupt-enable register whose writes that policy gates. Every bus access carries a secure attribute, a privilege attribute and an access size. A chip-level secure-mode enable input decides whether the secure-only bits are enforced at all.

A write to the interrupt-enable register passes three gates in fixed order. The first gate checks the size, which must be a full word. The second checks privilege, and an unprivileged access is silently dropped. The third applies the secure-only bit for the floating-point group, and only while secure mode is enabled. A rejected write leaves the register untouched, and all rejections except the unprivileged one raise a one-cycle error pulse. The block also drives one permit line per protected group. Registers that live elsewhere use these lines to decide whether a non-secure write may land on them. Read data is combinational from the address and attributes of the current access.

Top module: `sec_cfg_guard`

## Requirements
- R1: After reset the security policy register reads 0. Its bits 31:4 always read zero.
- R2: While secure mode is enabled and policy bit 3 is 1, a non-secure word write to the interrupt-enable register is dropped and raises the error pulse. A secure privileged word write still updates the register.
- R3: Output `nsWritePermit[i]` is 0 exactly when secure mode is enabled and policy bit i is 1. The group assignment is: bit 0 is the configuration-clock enables, bit 1 is the safety-class configuration, bit 2 is the SRAM1 key/status/write-protect group, and bit 3 is the floating-point interrupt-enable register.
- R4: While secure mode is disabled, no secure-only restriction applies, whatever the policy bits hold.
- R5: An unprivileged read of the interrupt-enable register returns 0. An unprivileged write to it has no effect and raises no error.
- R6: A write to the interrupt-enable register whose size is not a word (size code 2'b10; codes 2'b00 byte, 2'b01 half) is dropped and raises the error pulse.
- R7: The interrupt-enable register resets to 0x0000001F. Bits 5:0 are writable: bit 5 inexact, bit 4 input-denormal, bit 3 overflow, bit 2 underflow, bit 1 divide-by-zero, bit 0 invalid-operation. Bits 31:6 read zero. Bits 5:0 also appear on `fpuIntEn`.
- R8: `accessErr` is high in the single cycle after a rejected write and low otherwise.
- R9: The security policy register updates only on a secure, privileged, word write. Any other write to it is dropped and raises the error pulse.
- R10: A privileged read of the interrupt-enable register returns its value even when the security policy would block a write from the same master.
- R11: An access to any other offset reads zero, changes no register and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tzEnable | input | 1 | Chip secure-mode enable |
| busSel | input | 1 | Access valid this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte offset (policy at 0x00, interrupt enable at 0x48) |
| busSize | input | 2 | 00 byte, 01 half, 10 word |
| busSecure | input | 1 | Access is secure |
| busPriv | input | 1 | Access is privileged |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for the current access |
| accessErr | output | 1 | One-cycle pulse after a rejected write |
| nsWritePermit | output | 4 | Per-group non-secure write permit |
| fpuIntEn | output | 6 | Current interrupt-enable bits |

## Verification
The hardest case to reach is the one where the third gate must fire. It needs secure mode on and policy bit 3 set, and the policy can be set only by a secure privileged word write. A word-sized, privileged, non-secure write must then follow. Random traffic seldom lines up all of these. The stimulus therefore seeds the policy with a directed secure write. It then runs random bursts where size, privilege, security and the secure-mode input vary while policy writes succeed often enough that bit 3 toggles both ways. Directed steps then walk each gate in order, so that each rejection is seen from the gate that owns it.

// File: rtl/sec_cfg_guard_pkg.sv
package sec_cfg_guard_pkg;
  localparam int BUS_W     = 32;
  localparam int ADDR_W    = 8;
  localparam int NUM_GRP   = 4;
  localparam int FPU_BITS  = 6;
  localparam int FPU_GRP   = 3;
  localparam logic [1:0] SIZE_WORD = 2'b10;

  typedef struct packed {
    logic secWe;   // commit write to policy register
    logic fpuWe;   // commit write to interrupt-enable register
    logic errSet;  // rejected write this cycle
    logic rdSec;   // drive policy register on read bus
    logic rdFpu;   // drive interrupt-enable register on read bus
  } guardStrobes_t;
endpackage

// File: rtl/sec_cfg_guard_ctrl.sv
module sec_cfg_guard_ctrl
  import sec_cfg_guard_pkg::*;
#(
  parameter logic [ADDR_W-1:0] SEC_OFS = 8'h00,
  parameter logic [ADDR_W-1:0] FPU_OFS = 8'h48
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tzEnable,
  input  logic               busSel,
  input  logic               busWrite,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [1:0]         busSize,
  input  logic               busSecure,
  input  logic               busPriv,
  input  logic [NUM_GRP-1:0] secBits,
  output guardStrobes_t      strobes,
  output logic [NUM_GRP-1:0] nsWritePermit
);
  logic hitSec, hitFpu, isWord, fpuSecOnly;

  genvar g;
  generate
    for (g = 0; g < NUM_GRP; g++) begin : g_permit
      assign nsWritePermit[g] = !(tzEnable && secBits[g]);
    end
  endgenerate

  assign hitSec     = busSel && (busAddr == SEC_OFS);
  assign hitFpu     = busSel && (busAddr == FPU_OFS);
  assign isWord     = (busSize == SIZE_WORD);
  assign fpuSecOnly = !nsWritePermit[FPU_GRP];

  always_comb begin
    strobes = '0;
    strobes.rdSec = hitSec && !busWrite;
    strobes.rdFpu = hitFpu && !busWrite && busPriv;
    if (busWrite && hitSec) begin
      if (isWord && busPriv && busSecure) strobes.secWe  = 1'b1;
      else                                strobes.errSet = 1'b1;
    end
    if (busWrite && hitFpu) begin
      // layer 1: size, layer 2: privilege (silent), layer 3: secure-only
      if (!isWord)                         strobes.errSet = 1'b1;
      else if (!busPriv)                   strobes.errSet = 1'b0;
      else if (fpuSecOnly && !busSecure)   strobes.errSet = 1'b1;
      else                                 strobes.fpuWe  = 1'b1;
    end
  end

  p_tz_off_open_r4: assert property (@(posedge clk) disable iff (!rstN)
    !tzEnable |-> (&nsWritePermit));
  p_unpriv_silent_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWrite && !busPriv && busAddr == FPU_OFS && isWord)
      |-> !(strobes.fpuWe || strobes.errSet));
  p_size_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWrite && !isWord) |-> !(strobes.fpuWe || strobes.secWe));
  p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strobes.secWe, strobes.fpuWe, strobes.errSet}) <= 1);
endmodule

// File: rtl/sec_cfg_guard_regs.sv
module sec_cfg_guard_regs
  import sec_cfg_guard_pkg::*;
#(
  parameter logic [FPU_BITS-1:0] FPU_RST = 6'h1F
) (
  input  logic                clk,
  input  logic                rstN,
  input  guardStrobes_t       strobes,
  input  logic [BUS_W-1:0]    busWdata,
  output logic [NUM_GRP-1:0]  secBits,
  output logic [FPU_BITS-1:0] fpuBits,
  output logic [BUS_W-1:0]    busRdata,
  output logic                accessErr
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      secBits   <= '0;
      fpuBits   <= FPU_RST;
      accessErr <= 1'b0;
    end else begin
      if (strobes.secWe) secBits <= busWdata[NUM_GRP-1:0];
      if (strobes.fpuWe) fpuBits <= busWdata[FPU_BITS-1:0];
      accessErr <= strobes.errSet;
    end
  end

  always_comb begin
    busRdata = '0;
    if (strobes.rdSec)      busRdata[NUM_GRP-1:0]  = secBits;
    else if (strobes.rdFpu) busRdata[FPU_BITS-1:0] = fpuBits;
  end

  p_sec_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.secWe |=> $stable(secBits));
  p_fpu_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.fpuWe |=> $stable(fpuBits));
  p_err_follows_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.errSet |=> accessErr);
  p_upper_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    busRdata[BUS_W-1:FPU_BITS] == '0);
endmodule

// File: rtl/sec_cfg_guard.sv
module sec_cfg_guard
  import sec_cfg_guard_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        tzEnable,
  input  logic        busSel,
  input  logic        busWrite,
  input  logic [7:0]  busAddr,
  input  logic [1:0]  busSize,
  input  logic        busSecure,
  input  logic        busPriv,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  output logic        accessErr,
  output logic [3:0]  nsWritePermit,
  output logic [5:0]  fpuIntEn
);
  guardStrobes_t       strobes;
  logic [NUM_GRP-1:0]  secBits;

  sec_cfg_guard_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .tzEnable(tzEnable), .busSel(busSel),
    .busWrite(busWrite), .busAddr(busAddr), .busSize(busSize),
    .busSecure(busSecure), .busPriv(busPriv), .secBits(secBits),
    .strobes(strobes), .nsWritePermit(nsWritePermit)
  );

  sec_cfg_guard_regs u_regs (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busWdata(busWdata),
    .secBits(secBits), .fpuBits(fpuIntEn), .busRdata(busRdata),
    .accessErr(accessErr)
  );

  p_ns_block_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWrite && busAddr == 8'h48 && !busSecure && tzEnable
      && !nsWritePermit[3]) |=> $stable(fpuIntEn));
  p_unpriv_raz_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWrite && busAddr == 8'h48 && !busPriv) |-> busRdata == '0);
endmodule

// File: tb/sec_cfg_guard_bench.sv
module sec_cfg_guard_bench;
  logic clk = 0, rstN = 0, tzEnable = 0, busSel = 0, busWrite = 0;
  logic [7:0] busAddr = 0;
  logic [1:0] busSize = 0;
  logic busSecure = 0, busPriv = 0;
  logic [31:0] busWdata = 0, busRdata;
  logic accessErr;
  logic [3:0] nsWritePermit;
  logic [5:0] fpuIntEn;

  int checks = 0, fails = 0;
  logic [3:0] expSec;
  logic [5:0] expFpu;
  logic expErr;

  always #10 clk = ~clk;

  sec_cfg_guard u_sec_cfg_guard (.*);

  initial begin
    #3_000_000;
    fails++; checks++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] permitOf(input logic tz, input logic [3:0] s);
    return tz ? ~s : 4'hF;
  endfunction

  // one access: drive at negedge, check read data, then error pulse after the edge
  task automatic access(input logic wr, input logic [7:0] a, input logic [31:0] d,
                        input logic [1:0] sz, input logic sec, input logic pv,
                        input string req);
    logic [31:0] expRd;
    logic word;
    @(negedge clk);
    busSel = 1; busWrite = wr; busAddr = a; busWdata = d; busSize = sz;
    busSecure = sec; busPriv = pv;
    word = (sz == 2'b10);
    expErr = 0;
    #1;
    if (!wr) begin
      expRd = 0;
      if (a == 8'h00) expRd = {28'b0, expSec};
      else if (a == 8'h48 && pv) expRd = {26'b0, expFpu};
      check(req, busRdata, expRd);
    end else if (a == 8'h00) begin
      if (word && pv && sec) expSec = d[3:0]; else expErr = 1;
    end else if (a == 8'h48) begin
      if (!word) expErr = 1;
      else if (!pv) expErr = 0;
      else if (tzEnable && expSec[3] && !sec) expErr = 1;
      else expFpu = d[5:0];
    end
    @(negedge clk);
    busSel = 0;
    check({req, " err"}, {31'b0, accessErr}, {31'b0, expErr});
    check({req, " permit R3"}, {28'b0, nsWritePermit}, {28'b0, permitOf(tzEnable, expSec)});
    check({req, " fpuIntEn"}, {26'b0, fpuIntEn}, {26'b0, expFpu});
  endtask

  initial begin
    void'($urandom(32'd7));
    expSec = 0; expFpu = 6'h1F;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 / R7 reset state
    access(0, 8'h00, 0, 2'b10, 1, 1, "R1 reset policy");
    access(0, 8'h48, 0, 2'b10, 1, 1, "R7 reset fpu");
    // R7 writable bits, upper ignored
    access(1, 8'h48, 32'hFFFF_FFEA, 2'b10, 0, 1, "R7 write");
    access(0, 8'h48, 0, 2'b10, 0, 1, "R7 readback");
    // R1 upper policy bits read zero
    access(1, 8'h00, 32'hFFFF_FFF0, 2'b10, 1, 1, "R1 upper write");
    access(0, 8'h00, 0, 2'b10, 1, 1, "R1 upper read");
    // R9 rejected policy writes
    access(1, 8'h00, 32'h8, 2'b10, 0, 1, "R9 nonsecure");
    access(1, 8'h00, 32'h8, 2'b10, 1, 0, "R9 unpriv");
    access(1, 8'h00, 32'h8, 2'b01, 1, 1, "R9 half");
    access(1, 8'h00, 32'h8, 2'b10, 1, 1, "R9 good");
    // R4: tz off, policy bit 3 set, non-secure write allowed
    access(1, 8'h48, 32'h15, 2'b10, 0, 1, "R4 tz off write");
    // R2 / R3 / R10
    tzEnable = 1;
    access(1, 8'h48, 32'h3F, 2'b10, 0, 1, "R2 ns blocked");
    access(0, 8'h48, 0, 2'b10, 0, 1, "R10 blocked read");
    access(1, 8'h48, 32'h2A, 2'b10, 1, 1, "R2 secure ok");
    // R6 sizes
    access(1, 8'h48, 32'h01, 2'b00, 1, 1, "R6 byte");
    access(1, 8'h48, 32'h01, 2'b01, 1, 1, "R6 half");
    // R5 unprivileged
    access(1, 8'h48, 32'h00, 2'b10, 1, 0, "R5 unpriv write");
    access(0, 8'h48, 0, 2'b10, 1, 0, "R5 unpriv read");
    // R11 unmapped
    access(1, 8'h10, 32'hFFFF_FFFF, 2'b10, 1, 1, "R11 write");
    access(0, 8'h10, 0, 2'b10, 1, 1, "R11 read");
    // R8 pulse falls after a single cycle
    access(1, 8'h48, 32'h01, 2'b00, 1, 1, "R8 trigger");
    @(negedge clk);
    check("R8 pulse low", {31'b0, accessErr}, 32'b0);
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a;
      int pick;
      pick = $urandom_range(0, 4);
      a = (pick < 2) ? 8'h48 : (pick < 4 ? 8'h00 : 8'h10);
      if ($urandom_range(0, 9) == 0) tzEnable = $urandom_range(0, 1);
      access($urandom_range(0, 1), a, $urandom, $urandom_range(0, 3),
             $urandom_range(0, 1), $urandom_range(0, 3) != 0, "R2 random");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule